// File: doc/BRIEF.md
# Tear-Free Split 64-bit Reader

This block reads a 64-bit free-running value that is exposed as two 32-bit words, through a read port that only moves 32 bits at a time. A wrap of the low word into the high word can happen between two narrow reads, so a naive low-then-high read can return a torn value. The reader avoids this by bracketing each low-word read with two high-word reads and accepting the pair only when both high reads agree.

A client pulses `start` with a base address. The reader first fetches the high word at base+4. Each attempt then fetches the low word at base and the high word at base+4 again. The number of attempts is bounded. When the attempt limit runs out without agreement, the result is a fixed not-ready marker rather than data. Completion is signalled by a single-cycle `done`, and the result register holds until the next completion.

Top module: `tearfree_reader`

## Requirements
- R1: The first read request of every operation targets the high word at address base+4.
- R2: After the first read, each attempt issues exactly two requests in order: the low word at address base, then the high word at base+4.
- R3: When the high word read at the end of an attempt equals the high word read just before that attempt's low read, the result is {high, low}, with the high word in bits 63:32 and the low word in bits 31:0.
- R4: At most MAX_TRIES (default 3) attempts are made, so one operation issues at most 1 + 2*MAX_TRIES reads and stops at the first matching attempt.
- R5: If no attempt matches, the result is the not-ready marker, which has bit 63 set and all other bits zero.
- R6: `done` is high for exactly one cycle per operation; `busy` is high from the cycle after a start is accepted through the `done` cycle and low in the cycle after; `result` changes only when `done` rises.
- R7: A `start` that arrives while `busy` is high is ignored: it launches no reads, does not change the base address in use and produces no extra `done`.
- R8: Only one read is outstanding: `rdReqValid` stays high with a stable address until `rdReqReady`, and no new request is raised before the response of the previous one arrives on `rdRspValid` (responses come at least one cycle after the request handshake).
- R9: After reset `busy`, `done` and `rdReqValid` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| baseAddr | input | ADDR_W | Address of the low word; high word is at +4 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2*WORD_W | Assembled value or not-ready marker |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Read request accepted |
| rdReqAddr | output | ADDR_W | Read request address |
| rdRspValid | input | 1 | Read response valid |
| rdRspData | input | WORD_W | Read response data |

## Verification
The bench scripts the sequence of high and low words the responder hands back, so it can force a match on the first, second or last attempt, or a mismatch on every attempt; a reader that compared the wrong pair of high words, or kept the stale high word after a mismatch, would return a torn value or the marker when data was due. The failing case checks the read count and the marker, catching an off-by-one attempt limit that issues one read too many or too few, or a reader that returns the last torn pair. Starts are injected while busy with a different base, which a reader that re-arms mid-operation would expose through wrong addresses, extra reads or a second `done`. Random ready stalls and response latencies check that requests hold until accepted and that only one read is ever in flight.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBase;   // latch the base address
    logic selLow;     // current request targets the low word
    logic capHi;      // store response as reference high word
    logic capLo;      // store response as low word
    logic finishOk;   // commit {high, low} to the result
    logic finishBad;  // commit the not-ready marker
  } tfrStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_DONE
  } tfrStateT;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_LOW,
    PH_HIGH
  } tfrPhaseT;

endpackage

// File: rtl/tfr_ctrl.sv
module tfr_ctrl
  import tfr_pkg::*;
#(
  parameter int MAX_TRIES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rdReqReady,
  input  logic       rdRspValid,
  input  logic       hiMatch,
  output logic       busy,
  output logic       done,
  output logic       rdReqValid,
  output tfrStrobeT  strb
);

  localparam int TRY_W = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);

  tfrStateT          state;
  tfrStateT          stateNext;
  tfrPhaseT          phase;
  tfrPhaseT          phaseNext;
  logic [TRY_W-1:0]  tryCnt;
  logic [TRY_W-1:0]  tryCntNext;
  logic              lastTry;
  logic              rspHere;

  assign lastTry = (tryCnt == TRY_W'(MAX_TRIES - 1));
  assign rspHere = (state == ST_RSP) && rdRspValid;

  always_comb begin
    strb           = '0;
    stateNext      = state;
    phaseNext      = phase;
    tryCntNext     = tryCnt;
    strb.selLow    = (phase == PH_LOW);
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadBase = 1'b1;
          stateNext     = ST_REQ;
          phaseNext     = PH_FIRST;
          tryCntNext    = '0;
        end
      end
      ST_REQ: begin
        if (rdReqReady) stateNext = ST_RSP;
      end
      ST_RSP: begin
        if (rspHere) begin
          case (phase)
            PH_FIRST: begin
              strb.capHi = 1'b1;
              phaseNext  = PH_LOW;
              stateNext  = ST_REQ;
            end
            PH_LOW: begin
              strb.capLo = 1'b1;
              phaseNext  = PH_HIGH;
              stateNext  = ST_REQ;
            end
            default: begin
              if (hiMatch) begin
                strb.finishOk = 1'b1;
                stateNext     = ST_DONE;
              end else if (lastTry) begin
                strb.finishBad = 1'b1;
                stateNext      = ST_DONE;
              end else begin
                strb.capHi = 1'b1;
                tryCntNext = tryCnt + 1'b1;
                phaseNext  = PH_LOW;
                stateNext  = ST_REQ;
              end
            end
          endcase
        end
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_FIRST;
      tryCnt <= '0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      tryCnt <= tryCntNext;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign rdReqValid = (state == ST_REQ);

  // R6: completion is a single-cycle pulse
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an offered request is held until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> rdReqValid);

  // R4: attempt counter never passes the limit
  p_try_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < TRY_W'(MAX_TRIES));

  // R3: completion only follows a response
  p_done_after_rsp_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(rdRspValid));

endmodule

// File: rtl/tfr_dpath.sv
module tfr_dpath
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tfrStrobeT             strb,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [WORD_W-1:0]     rdRspData,
  output logic [ADDR_W-1:0]     rdReqAddr,
  output logic                  hiMatch,
  output logic [2*WORD_W-1:0]   result
);

  localparam int RES_W = 2 * WORD_W;
  localparam logic [RES_W-1:0] NOT_READY = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] HI_OFFSET = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] baseReg;
  logic [WORD_W-1:0] refHi;
  logic [WORD_W-1:0] lowWord;

  assign rdReqAddr = strb.selLow ? baseReg : (baseReg + HI_OFFSET);
  assign hiMatch   = (rdRspData == refHi);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
      refHi   <= '0;
      lowWord <= '0;
      result  <= '0;
    end else begin
      if (strb.loadBase)  baseReg <= baseAddr;
      if (strb.capHi)     refHi   <= rdRspData;
      if (strb.capLo)     lowWord <= rdRspData;
      if (strb.finishOk)  result  <= {refHi, lowWord};
      if (strb.finishBad) result  <= NOT_READY;
    end
  end

  // R5: a failed operation leaves the marker in the result
  p_marker_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishBad |=> (result == NOT_READY));

  // R6: result only moves on a commit
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.finishOk && !strb.finishBad) |=> $stable(result));

endmodule

// File: rtl/tearfree_reader.sv
module tearfree_reader
  import tfr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int MAX_TRIES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     baseAddr,
  output logic                  busy,
  output logic                  done,
  output logic [2*WORD_W-1:0]   result,
  output logic                  rdReqValid,
  input  logic                  rdReqReady,
  output logic [ADDR_W-1:0]     rdReqAddr,
  input  logic                  rdRspValid,
  input  logic [WORD_W-1:0]     rdRspData
);

  tfrStrobeT strb;
  logic      hiMatch;

  tfr_ctrl #(.MAX_TRIES(MAX_TRIES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rdReqReady (rdReqReady),
    .rdRspValid (rdRspValid),
    .hiMatch    (hiMatch),
    .busy       (busy),
    .done       (done),
    .rdReqValid (rdReqValid),
    .strb       (strb)
  );

  tfr_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .rdRspData (rdRspData),
    .rdReqAddr (rdReqAddr),
    .hiMatch   (hiMatch),
    .result    (result)
  );

  // R8: request address holds while a request waits
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> $stable(rdReqAddr));

endmodule

// File: tb/tearfree_reader_tb.sv
module tearfree_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int TRIES  = 3;
  localparam logic [63:0] MARKER = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        busy, done, rdReqValid;
  logic [63:0] result;
  logic        rdReqReady = 1'b0;
  logic [31:0] rdReqAddr;
  logic        rdRspValid = 1'b0;
  logic [31:0] rdRspData = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] hiSeq [4];
  logic [31:0] loSeq [3];
  logic [31:0] txnBase;
  int rdIdx, hiIdx, loIdx;
  int pend = 0;
  logic [31:0] pendData;
  int doneTotal = 0;
  logic prevDone = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tearfree_reader #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_TRIES(TRIES)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .busy(busy), .done(done), .result(result),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdRspValid(rdRspValid), .rdRspData(rdRspData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expValue();
    logic [31:0] ref_hi = hiSeq[0];
    for (int a = 0; a < TRIES; a++) begin
      if (hiSeq[a+1] == ref_hi) return {hiSeq[a+1], loSeq[a]};
      ref_hi = hiSeq[a+1];
    end
    return MARKER;
  endfunction

  function automatic int expReads();
    logic [31:0] ref_hi = hiSeq[0];
    for (int a = 0; a < TRIES; a++) begin
      if (hiSeq[a+1] == ref_hi) return 3 + 2*a;
      ref_hi = hiSeq[a+1];
    end
    return 1 + 2*TRIES;
  endfunction

  // Responder: one negedge loop drives ready and responses
  initial begin
    forever begin
      @(negedge clk);
      rdRspValid = 1'b0;
      rdReqReady = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rdRspValid = 1'b1;
          rdRspData  = pendData;
        end
      end
      if (rdReqValid && pend > 0)
        check(1'b0, "R8 second request outstanding", 64'(rdReqAddr), 64'(0));
      if (rdReqValid && pend == 0 && ($urandom % 3 != 0)) begin
        rdReqReady = 1'b1;
        if (rdIdx == 0 || rdIdx % 2 == 0) begin
          check(rdReqAddr == txnBase + 32'd4, rdIdx == 0 ? "R1 first read address" : "R2 high read address",
                64'(rdReqAddr), 64'(txnBase + 32'd4));
          if (hiIdx < 4) pendData = hiSeq[hiIdx]; else pendData = '0;
          hiIdx++;
        end else begin
          check(rdReqAddr == txnBase, "R2 low read address", 64'(rdReqAddr), 64'(txnBase));
          if (loIdx < 3) pendData = loSeq[loIdx]; else pendData = '0;
          loIdx++;
        end
        rdIdx++;
        pend = 1 + ($urandom % 3);
      end
    end
  end

  // Monitor: done width
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (done) begin
          doneTotal++;
          if (prevDone) check(1'b0, "R6 done longer than one cycle", 64'(1), 64'(0));
        end
        prevDone = done;
      end
    end
  end

  task automatic runTxn(input logic [31:0] base, input bit inject);
    logic [63:0] expV = expValue();
    int expN = expReads();
    int doneBefore = doneTotal;
    logic [63:0] resBefore = result;
    int guard = 0;
    rdIdx = 0; hiIdx = 0; loIdx = 0;
    txnBase = base;
    @(negedge clk);
    start = 1'b1;
    baseAddr = base;
    @(negedge clk);
    start = 1'b0;
    baseAddr = ~base;
    check(busy == 1'b1, "R6 busy after start", 64'(busy), 64'(1));
    while (!done && guard < 500) begin
      if (!done) check(result == resBefore, "R6 result held until done", result, resBefore);
      @(negedge clk);
      start = inject && ($urandom % 2 == 1) && !done;
      guard++;
    end
    start = 1'b0;
    if (guard >= 500) begin
      check(1'b0, "R6 watchdog no done", 64'(0), 64'(1));
      return;
    end
    check(result == expV, expV == MARKER ? "R5 marker result" : "R3 assembled result", result, expV);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R6 idle after done", {busy, done}, 64'(0));
    check(rdIdx == expN, "R4 read count", 64'(rdIdx), 64'(expN));
    check(doneTotal == doneBefore + 1, "R7 single done per operation", 64'(doneTotal - doneBefore), 64'(1));
    repeat (3) @(negedge clk);
    check(rdIdx == expN, "R7 no reads after done", 64'(rdIdx), 64'(expN));
  endtask

  task automatic setSeq(input logic [31:0] h0, h1, h2, h3, l0, l1, l2);
    hiSeq[0] = h0; hiSeq[1] = h1; hiSeq[2] = h2; hiSeq[3] = h3;
    loSeq[0] = l0; loSeq[1] = l1; loSeq[2] = l2;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1234_abcd);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 busy in reset", 64'(busy), 64'(0));
    check(done == 1'b0, "R9 done in reset", 64'(done), 64'(0));
    check(rdReqValid == 1'b0, "R9 request in reset", 64'(rdReqValid), 64'(0));
    check(result == 64'd0, "R9 result in reset", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: match on first, second, last attempt; never match
    setSeq(32'h0000_0007, 32'h0000_0007, 32'h0, 32'h0, 32'hdead_beef, 32'h1, 32'h2);
    runTxn(32'h0000_1000, 1'b0);
    setSeq(32'h0000_0007, 32'h0000_0008, 32'h0000_0008, 32'h0, 32'hffff_fff0, 32'h0000_0010, 32'h2);
    runTxn(32'h0000_2000, 1'b1);
    setSeq(32'h1, 32'h2, 32'h3, 32'h3, 32'h11, 32'h22, 32'h33);
    runTxn(32'h0000_3000, 1'b1);
    setSeq(32'h1, 32'h2, 32'h3, 32'h4, 32'h11, 32'h22, 32'h33);
    runTxn(32'h0000_4000, 1'b0);
    // Data that looks like the marker but is valid
    setSeq(32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    runTxn(32'hffff_fff8, 1'b0);

    // Random with small high-word spread to provoke mismatches
    for (int t = 0; t < 60; t++) begin
      logic [31:0] hb = $urandom;
      for (int i = 0; i < 4; i++) hiSeq[i] = hb + ($urandom % 2);
      for (int i = 0; i < 3; i++) loSeq[i] = $urandom;
      runTxn({$urandom} & 32'hffff_fffc, ($urandom % 2) == 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R6 global watchdog expired actual=%h expected=%h", 64'(0), 64'(1));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule